// File: doc/BRIEF.md
# Divide-by-7/8 Dual-Modulus Prescaler

This block divides a fast input clock by eight or by seven, depending on a single modulus-select input. It is the front stage of a pulse-swallow style programmable divider. A downstream counter steers the modulus so that, over one of its own cycles, some output periods last eight input cycles and the rest last seven. The block has two outputs: the divided clock, and a one-cycle enable pulse that marks the start of every output period so the downstream counter can advance synchronously.

The divider is built from two stages. The first is a divide-by-3/4 core, a two-bit state machine with states CS_0, CS_1, CS_2 and CS_3. Its transitions are CS_0→CS_1, CS_1→CS_2, CS_2→CS_3 and CS_3→CS_0, plus a short transition CS_2→CS_0 when the core is told to count by three. The second stage is a divide-by-2 half stage with states HS_LO and HS_HI, which toggles each time the core wraps. Together they form a three-bit phase {half, core}.

The modulus is held in a latch with states MD_DIV8 and MD_DIV7. The latch loads only at the edge where the phase returns to 000, and its transitions are MD_DIV8↔MD_DIV7 at that edge. In MD_DIV7 the core counts by three during the upper half, so phase 110 is followed by 000 and phase 111 is skipped. The divided clock is the half-stage bit.

Top module: `dmod_prescaler`

## Requirements
- R1: When the modulus latched at the start of an output period is 0, that period lasts exactly 8 input clock cycles.
- R2: When the modulus latched at the start of an output period is 1, that period lasts exactly 7 input clock cycles.
- R3: The phase output is {half-stage bit, core bits[1:0]}. Within a period it starts at 0 and rises by one on every input clock edge, so the core counts 0..3 or 0..2 and the half stage toggles on each core wrap.
- R4: In divide-by-7 periods the phase value 7 (all three bits high) never appears, and phase 6 is followed by phase 0.
- R5: In divide-by-8 periods every phase value 0 through 7 appears.
- R6: The modulus input is sampled only at the clock edge on which the phase returns to 0. Changes at any other time do not affect the period in progress.
- R7: A synchronous active-high reset sets the phase to 0 and drives the divided clock and the pulse to 0. It also sets the latched modulus to divide-by-8, so the first period after reset lasts 8 cycles whatever the modulus input is.
- R8: The boundary pulse is high for exactly one input cycle: the cycle with phase 0 that is entered by a wrap from the end of a period. It is low in all other cycles.
- R9: The divided clock is high while phase bit 2 is 1. It is high for 4 of 8 cycles in divide-by-8 periods and 3 of 7 cycles in divide-by-7 periods, and it rises when the phase enters 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate input clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_sel | input | 1 | Modulus select: 0 divides by 8, 1 divides by 7 |
| div_clk | output | 1 | Divided clock (half-stage bit) |
| cyc_pulse | output | 1 | One-cycle pulse in the first input cycle of each output period |
| phase | output | 3 | Current state {half, core[1:0]} |

## Verification
The phase moves on every rising edge. The pulse and a phase of 0 appear one edge after the last state of a period, so the pulse is due 8 or 7 edges after the previous one, and 8 edges after reset is released. A change on mod_sel first matters at the next return to phase 0, never earlier. The bench therefore drives mod_sel and rst on falling edges and samples the outputs on falling edges before it drives anything. Each measured period is judged against the mod_sel value that was held across the rising edge which produced that period's pulse, and this holds even when mod_sel toggles every few cycles.

// File: rtl/dmod_pkg.sv
package dmod_pkg;
    localparam int CORE_W  = 2;
    localparam int PHASE_W = CORE_W + 1;

    typedef enum logic [CORE_W-1:0] {
        CS_0 = 2'b00,
        CS_1 = 2'b01,
        CS_2 = 2'b10,
        CS_3 = 2'b11
    } core_st_t;

    typedef enum logic {
        HS_LO = 1'b0,
        HS_HI = 1'b1
    } half_st_t;

    typedef enum logic {
        MD_DIV8 = 1'b0,
        MD_DIV7 = 1'b1
    } mode_st_t;
endpackage

// File: rtl/dmod_core34.sv
module dmod_core34
    import dmod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              short_i,
    output logic [CORE_W-1:0] state_o,
    output logic              wrap_o
);
    core_st_t st_q;
    core_st_t st_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= CS_0;
        else     st_q <= st_d;
    end

    // next state: short count skips CS_3
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CS_0: st_d = CS_1;
            CS_1: st_d = CS_2;
            CS_2: st_d = short_i ? CS_0 : CS_3;
            CS_3: st_d = CS_0;
        endcase
    end

    // outputs
    always_comb begin
        wrap_o = 1'b0;
        unique case (st_q)
            CS_0, CS_1: wrap_o = 1'b0;
            CS_2:       wrap_o = short_i;
            CS_3:       wrap_o = 1'b1;
        endcase
    end

    assign state_o = st_q;
endmodule

// File: rtl/dmod_half.sv
module dmod_half
    import dmod_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv_i,
    output logic half_o
);
    half_st_t hs_q;
    half_st_t hs_d;

    always_ff @(posedge clk) begin
        if (rst) hs_q <= HS_LO;
        else     hs_q <= hs_d;
    end

    always_comb begin
        hs_d = hs_q;
        unique case (hs_q)
            HS_LO: if (adv_i) hs_d = HS_HI;
            HS_HI: if (adv_i) hs_d = HS_LO;
        endcase
    end

    assign half_o = (hs_q == HS_HI);
endmodule

// File: rtl/dmod_mode_latch.sv
module dmod_mode_latch
    import dmod_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sample_i,
    input  logic mod_i,
    output logic div7_o
);
    mode_st_t md_q;
    mode_st_t md_d;

    always_ff @(posedge clk) begin
        if (rst) md_q <= MD_DIV8;
        else     md_q <= md_d;
    end

    always_comb begin
        md_d = md_q;
        unique case (md_q)
            MD_DIV8: if (sample_i && mod_i)  md_d = MD_DIV7;
            MD_DIV7: if (sample_i && !mod_i) md_d = MD_DIV8;
        endcase
    end

    assign div7_o = (md_q == MD_DIV7);
endmodule

// File: rtl/dmod_prescaler.sv
module dmod_prescaler
    import dmod_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mod_sel,
    output logic               div_clk,
    output logic               cyc_pulse,
    output logic [PHASE_W-1:0] phase
);
    logic [CORE_W-1:0] core_st;
    logic              core_wrap;
    logic              half_q;
    logic              mode_q;
    logic              short_cyc;
    logic              cyc_end;
    logic              pulse_q;

    // count by three only in the upper half of a divide-by-7 period
    assign short_cyc = mode_q & half_q;
    assign cyc_end   = core_wrap & half_q;

    dmod_core34 u_core (
        .clk     (clk),
        .rst     (rst),
        .short_i (short_cyc),
        .state_o (core_st),
        .wrap_o  (core_wrap)
    );

    dmod_half u_half (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (core_wrap),
        .half_o (half_q)
    );

    dmod_mode_latch u_mode (
        .clk      (clk),
        .rst      (rst),
        .sample_i (cyc_end),
        .mod_i    (mod_sel),
        .div7_o   (mode_q)
    );

    // boundary pulse register
    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= cyc_end;
    end

    assign div_clk   = half_q;
    assign cyc_pulse = pulse_q;
    assign phase     = {half_q, core_st};
endmodule

// File: rtl/dmod_prescaler_chk.sv
module dmod_prescaler_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_q,
    input logic [2:0] phase,
    input logic       div_clk,
    input logic       cyc_pulse
);
    a_r1_div8_wrap: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && phase == 3'd7) |=> (phase == 3'd0 && cyc_pulse));

    a_r2_div7_wrap: assert property (@(posedge clk) disable iff (rst)
        (mode_q && phase == 3'd6) |=> (phase == 3'd0 && cyc_pulse));

    a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
        (phase != 3'd7 && !(mode_q && phase == 3'd6)) |=> (phase == 3'($past(phase) + 3'd1)));

    a_r4_no_state7: assert property (@(posedge clk) disable iff (rst)
        mode_q |-> (phase != 3'd7));

    a_r6_mode_hold: assert property (@(posedge clk) disable iff (rst)
        (phase != 3'd0) |-> $stable(mode_q));

    a_r7_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (phase == 3'd0 && !cyc_pulse && !div_clk));

    a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
        cyc_pulse |=> !cyc_pulse);

    a_r8_pulse_phase: assert property (@(posedge clk) disable iff (rst)
        cyc_pulse |-> (phase == 3'd0));

    a_r9_clk_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(div_clk) |-> (phase == 3'd4));
endmodule

bind dmod_prescaler dmod_prescaler_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (mode_q),
    .phase     (phase),
    .div_clk   (div_clk),
    .cyc_pulse (cyc_pulse)
);

// File: tb/dmod_prescaler_bench.sv
`timescale 1ns/1ps
module dmod_prescaler_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mod_sel = 1'b1;
    logic       div_clk;
    logic       cyc_pulse;
    logic [2:0] phase;

    int checks = 0;
    int failures = 0;
    int gcnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmod_prescaler u_dmod_prescaler (
        .clk       (clk),
        .rst       (rst),
        .mod_sel   (mod_sel),
        .div_clk   (div_clk),
        .cyc_pulse (cyc_pulse),
        .phase     (phase)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Count falling edges until the pulse shows; returns the count.
    task automatic count_to_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cyc_pulse && n < 20);
    endtask

    // Watch nper whole periods; toggle mod_sel every 'tog' cycles when tog > 0.
    task automatic watch(input int nper, input int tog, input string ctx);
        int guard = 0;
        while (!cyc_pulse && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        chk(cyc_pulse, {ctx, " R8 sync pulse"}, cyc_pulse, 1);
        for (int p = 0; p < nper; p++) begin
            bit   exp7;
            int   idx;
            int   hi;
            logic [7:0] seen;
            int   explen;
            exp7 = mod_sel;
            idx  = 0;
            hi   = 0;
            seen = 8'h00;
            explen = exp7 ? 7 : 8;
            do begin
                chk(phase == 3'(idx), {ctx, " R3 phase step"}, phase, idx);
                if (idx == 4) chk(div_clk == 1'b1, {ctx, " R9 rise at phase 4"}, div_clk, 1);
                hi += div_clk;
                seen[phase] = 1'b1;
                gcnt++;
                if (tog > 0 && (gcnt % tog) == 0) mod_sel = ~mod_sel;
                @(negedge clk);
                idx++;
            end while (!cyc_pulse && idx < 20);
            chk(idx == explen, exp7 ? {ctx, " R2 R6 period"} : {ctx, " R1 R6 period"}, idx, explen);
            chk(hi == explen - 4, {ctx, " R9 high cycles"}, hi, explen - 4);
            if (exp7) chk(seen[7] == 1'b0, {ctx, " R4 phase 7 absent"}, seen[7], 0);
            else      chk(seen == 8'hFF, {ctx, " R5 all phases"}, seen, 255);
        end
    endtask

    task automatic t_reset();
        int n;
        @(negedge clk);
        chk(phase == 3'd0, "R7 reset phase", phase, 0);
        chk(div_clk == 1'b0, "R7 reset div_clk", div_clk, 0);
        chk(cyc_pulse == 1'b0, "R7 reset pulse", cyc_pulse, 0);
        rst = 1'b0;
        count_to_pulse(n);
        chk(n == 8, "R7 first period is 8 with mod_sel=1", n, 8);
    endtask

    task automatic t_div7();
        mod_sel = 1'b1;
        watch(3, 0, "div7");
    endtask

    task automatic t_div8();
        mod_sel = 1'b0;
        @(negedge clk);
        watch(3, 0, "div8");
    endtask

    task automatic t_midcycle(input int tog);
        watch(12, tog, "toggle");
    endtask

    task automatic t_reset_mid();
        int n;
        mod_sel = 1'b1;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(phase == 3'd0, "R7 mid reset phase", phase, 0);
        chk(div_clk == 1'b0, "R7 mid reset div_clk", div_clk, 0);
        chk(cyc_pulse == 1'b0, "R7 mid reset pulse", cyc_pulse, 0);
        @(negedge clk);
        rst = 1'b0;
        count_to_pulse(n);
        chk(n == 8, "R7 first period after mid reset", n, 8);
        watch(2, 0, "after reset div7");
    endtask

    initial begin
        t_reset();
        t_div7();
        t_div8();
        t_midcycle(3);
        t_midcycle(5);
        t_midcycle(11);
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            report();
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end
endmodule